// File: doc/BRIEF.md
# Serial Management Master with Programmable Clock Divider

This block drives the two-wire station management bus used to configure Ethernet PHY devices. It derives the management clock (MDC) from the system clock through a programmable divider. On request it shifts out a read or write management frame on the data line (MDIO), and it can prepend a run of ones as a preamble.

Software-side logic supplies a divider setting, a preamble-suppress flag and a one-cycle start strobe. The strobe carries the operation, the PHY and register addresses and the write data. The block returns the 16-bit read result and a one-cycle completion strobe. A divider setting of zero parks the clock low and keeps new frames from starting. A new setting takes effect only at an MDC edge, so no runt half-period ever appears on the wire.

Top module: `mdio_master`

## Requirements
- R1: For a non-zero divider setting N, each MDC half-period lasts 2·N system clocks, so one MDC period is 4·N system clocks. With N = 5 the period is 20 system clocks.
- R2: While the active divider setting is zero, MDC is held low. If the setting is zeroed while MDC is high, MDC goes low at the end of the current half-period and then stays low.
- R3: A start strobe is accepted only when the divider input is non-zero and no frame is in progress. Any other strobe is ignored: no bits are driven, no completion strobe follows, and the frame in progress is not disturbed.
- R4: With a constant divider setting, the MDC high and low phases have equal length.
- R5: A divider value changed while MDC runs is taken up at the next MDC edge. The half-period already under way finishes at the old length, and the following half-periods use the new one.
- R6: With the preamble-suppress flag clear, a frame opens with 32 ones, for 64 MDIO bit times in total. With the flag set, it opens directly with the start pattern, for 32 bit times.
- R7: After the optional preamble, the frame carries these fields MSB first: start `01`, opcode (`01` write, `10` read), 5-bit PHY address, 5-bit register address, 2-bit turnaround, 16 data bits. MDIO and its enable change only in the system clock that follows an MDC falling edge.
- R8: On a write, the turnaround is driven as `10` and the 16 data bits are driven. On a read, the output enable is low from the first turnaround bit through the last data bit.
- R9: On a read, MDIO is sampled on each of the 16 MDC rising edges of the data field, MSB first. The result appears on `rd_data` with the completion strobe and holds until the next accepted start, which clears it to zero.
- R10: `done` is high for exactly one system clock, in the clock after the MDC falling edge that ends the last data bit. The output enable is low from then on.
- R11: Synchronous active-low reset: MDC, MDIO out, output enable, `done` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed | input | SPEED_W (8) | Divider setting N; zero stops MDC |
| no_preamble | input | 1 | 1 = omit the 32-one preamble |
| start | input | 1 | One-cycle frame request |
| op_read | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Write payload |
| mdio_in | input | 1 | Sampled MDIO line |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| rd_data | output | 16 | Captured read payload |
| done | output | 1 | One-cycle frame completion strobe |

## Verification
The frame logic is exercised with a write and a read that both carry the preamble, then a read and a write without it, at divider settings 5, 1 and 2. These cases separate the 64- and 32-bit layouts, driven turnaround from released turnaround, and sampling alignment at the shortest and a longer half-period. The divider is run at a fixed value to measure period and duty. A value change mid-phase shows whether the old half-period is completed. Dropping to zero with MDC high shows the clock parking low. Start strobes sent while stopped and while busy confirm that they are ignored. Read payloads use asymmetric patterns, so that a one-bit sampling slip or a reversed bit order changes the result.

// File: rtl/mdio_pkg.sv
// Package: shared constants and the request record for the management master.
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int BODY_BITS  = 32;
    localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
    localparam int DATA_BITS  = 16;
    localparam int ADDR_BITS  = 5;
    localparam int LEFT_W     = $clog2(FRAME_BITS + 1);
    // Bits at the body tail that a read frame releases: turnaround plus data.
    localparam int REL_BITS   = DATA_BITS + 2;

    localparam logic [1:0] SOF_PAT = 2'b01;
    localparam logic [1:0] OPC_WR  = 2'b01;
    localparam logic [1:0] OPC_RD  = 2'b10;
    localparam logic [1:0] TA_WR   = 2'b10;

    typedef struct packed {
        logic                 rd;
        logic [ADDR_BITS-1:0] phy;
        logic [ADDR_BITS-1:0] regad;
        logic [DATA_BITS-1:0] wdata;
    } mgmt_req_t;
endpackage

// File: rtl/mdc_divider.sv
// Module: mdc_divider
// Divides the system clock down to MDC. Each half-period lasts 2*N clocks,
// where N is the divider setting latched at the last MDC edge. Assumes the
// setting input may change at any time. A latched zero parks MDC low.
// rise_p / fall_p are high in the clock in which mdc shows its new level.
module mdc_divider #(
    parameter int SPEED_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed,
    output logic               mdc,
    output logic               rise_p,
    output logic               fall_p
);
    localparam int CNT_W = SPEED_W + 2;

    logic [SPEED_W-1:0] n_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   half_last;
    logic               running;
    logic               half_end;

    // Purpose: last count value of a half-period at the latched setting.
    always_comb begin
        half_last = {1'b0, n_q, 1'b0} - CNT_W'(1);
        running   = (n_q != '0);
        half_end  = running && (cnt_q == half_last);
    end

    // Purpose: count half-periods, toggle MDC, latch a new setting at edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            cnt_q  <= '0;
            mdc    <= 1'b0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (!running) begin
                mdc   <= 1'b0;
                cnt_q <= '0;
                n_q   <= speed;
            end else if (half_end) begin
                cnt_q <= '0;
                n_q   <= speed;
                if (speed == '0) begin
                    mdc    <= 1'b0;
                    fall_p <= mdc;
                end else begin
                    mdc    <= ~mdc;
                    rise_p <= ~mdc;
                    fall_p <= mdc;
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/mdio_frame_pack.sv
// Module: mdio_frame_pack
// Builds the left-aligned serial image of one management frame, the matching
// per-bit drive mask and the bit count. Purely combinational. Assumes
// the consumer shifts MSB first and stops after nbits bits.
module mdio_frame_pack
    import mdio_pkg::*;
(
    input  mgmt_req_t               req,
    input  logic                    no_preamble,
    output logic [FRAME_BITS-1:0]   bits,
    output logic [FRAME_BITS-1:0]   drive,
    output logic [LEFT_W-1:0]       nbits
);
    logic [BODY_BITS-1:0] body;
    logic [BODY_BITS-1:0] body_oe;

    // Purpose: assemble the frame body and its drive mask per bit.
    always_comb begin
        body = {SOF_PAT,
                req.rd ? OPC_RD : OPC_WR,
                req.phy,
                req.regad,
                req.rd ? 2'b00 : TA_WR,
                req.rd ? {DATA_BITS{1'b0}} : req.wdata};
        for (int i = 0; i < BODY_BITS; i++) begin
            body_oe[i] = !(req.rd && (i < REL_BITS));
        end
    end

    // Purpose: place the body behind or in place of the preamble.
    always_comb begin
        if (no_preamble) begin
            bits  = {body, {PRE_BITS{1'b0}}};
            drive = {body_oe, {PRE_BITS{1'b0}}};
            nbits = LEFT_W'(BODY_BITS);
        end else begin
            bits  = {{PRE_BITS{1'b1}}, body};
            drive = {{PRE_BITS{1'b1}}, body_oe};
            nbits = LEFT_W'(FRAME_BITS);
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: mdio_frame_seq
// Shifts a packed frame onto MDIO, one bit per MDC falling edge. Samples
// read data on MDC rising edges during the data field. Ends with a
// one-clock done strobe. Assumes accept is high only when idle.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  is_read,
    input  logic [FRAME_BITS-1:0] bits,
    input  logic [FRAME_BITS-1:0] drive,
    input  logic [LEFT_W-1:0]     nbits,
    input  logic                  rise_p,
    input  logic                  fall_p,
    input  logic                  mdio_in,
    output logic                  busy,
    output logic                  rd_mode,
    output logic [LEFT_W-1:0]     left,
    output logic                  mdio_out,
    output logic                  mdio_oe,
    output logic [DATA_BITS-1:0]  rd_data,
    output logic                  done
);
    logic [FRAME_BITS-1:0] sh_q;
    logic [FRAME_BITS-1:0] oe_sh_q;
    logic [DATA_BITS-1:0]  rx_q;
    logic                  in_data;

    // Purpose: flag rising edges that fall inside the read data field.
    always_comb begin
        in_data = rd_mode && (left < LEFT_W'(DATA_BITS));
    end

    // Purpose: frame load, bit shifting, read capture and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            oe_sh_q  <= '0;
            rx_q     <= '0;
            left     <= '0;
            busy     <= 1'b0;
            rd_mode  <= 1'b0;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (accept) begin
                    sh_q    <= bits;
                    oe_sh_q <= drive;
                    left    <= nbits;
                    busy    <= 1'b1;
                    rd_mode <= is_read;
                    rx_q    <= '0;
                    rd_data <= '0;
                end
            end else begin
                if (fall_p) begin
                    if (left != '0) begin
                        mdio_out <= sh_q[FRAME_BITS-1];
                        mdio_oe  <= oe_sh_q[FRAME_BITS-1];
                        sh_q     <= {sh_q[FRAME_BITS-2:0], 1'b0};
                        oe_sh_q  <= {oe_sh_q[FRAME_BITS-2:0], 1'b0};
                        left     <= left - LEFT_W'(1);
                    end else begin
                        busy     <= 1'b0;
                        done     <= 1'b1;
                        mdio_out <= 1'b0;
                        mdio_oe  <= 1'b0;
                        if (rd_mode) begin
                            rd_data <= rx_q;
                        end
                    end
                end
                if (rise_p && in_data) begin
                    rx_q <= {rx_q[DATA_BITS-2:0], mdio_in};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: mdio_master
// Station management master: divider, frame packer and frame sequencer.
// Assumes start is a single-clock strobe. Requests that arrive while stopped
// or busy are dropped. Every output comes straight from a register.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SPEED_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SPEED_W-1:0]   speed,
    input  logic                 no_preamble,
    input  logic                 start,
    input  logic                 op_read,
    input  logic [ADDR_BITS-1:0] phy_addr,
    input  logic [ADDR_BITS-1:0] reg_addr,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 mdio_in,
    output logic                 mdc,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 done
);
    logic                  rise_p;
    logic                  fall_p;
    logic                  seq_busy;
    logic                  seq_rd;
    logic [LEFT_W-1:0]     seq_left;
    logic                  accept;
    mgmt_req_t             req;
    logic [FRAME_BITS-1:0] f_bits;
    logic [FRAME_BITS-1:0] f_drive;
    logic [LEFT_W-1:0]     f_nbits;

    // Purpose: gather the request and qualify the start strobe.
    always_comb begin
        req.rd    = op_read;
        req.phy   = phy_addr;
        req.regad = reg_addr;
        req.wdata = wr_data;
        accept    = start && !seq_busy && (speed != '0);
    end

    mdc_divider #(.SPEED_W(SPEED_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .speed  (speed),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame_pack u_pack (
        .req         (req),
        .no_preamble (no_preamble),
        .bits        (f_bits),
        .drive       (f_drive),
        .nbits       (f_nbits)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .is_read  (op_read),
        .bits     (f_bits),
        .drive    (f_drive),
        .nbits    (f_nbits),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .mdio_in  (mdio_in),
        .busy     (seq_busy),
        .rd_mode  (seq_rd),
        .left     (seq_left),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data),
        .done     (done)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: mdio_master_chk
// Property checker for mdio_master, attached by the bind below. It looks at
// ports and at the strobes exchanged between the divider and the sequencer.
module mdio_master_chk
    import mdio_pkg::*;
#(
    parameter int SPEED_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SPEED_W-1:0] speed,
    input logic               mdc,
    input logic               mdio_out,
    input logic               mdio_oe,
    input logic               done,
    input logic               busy,
    input logic               rd_mode,
    input logic [LEFT_W-1:0]  left,
    input logic               rise_p,
    input logic               fall_p
);
    // R2: a stopped, low clock stays low while the setting is zero.
    assert_stop_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (speed == '0 && !mdc) |=> !mdc);

    // R3: no frame begins while the divider setting is zero.
    assert_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && speed == '0) |=> !busy);

    // R4: the edge strobes agree with the clock level they announce.
    assert_rise_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |-> mdc);
    assert_fall_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_p |-> !mdc);

    // R7: MDIO value and enable move only right after a falling edge.
    assert_out_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_out) |-> $past(fall_p));
    assert_oe_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $past(fall_p));

    // R8: a read releases the line from turnaround through the data field.
    assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_mode && int'(left) < REL_BITS) |-> !mdio_oe);

    // R10: completion strobe lasts one clock and leaves the line released.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mdio_oe && !busy));
endmodule

bind mdio_master mdio_master_chk #(.SPEED_W(SPEED_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .speed    (speed),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .busy     (seq_busy),
    .rd_mode  (seq_rd),
    .left     (seq_left),
    .rise_p   (rise_p),
    .fall_p   (fall_p)
);

// File: tb/mdio_master_test.sv
// Bench for mdio_master. A behavioural model is advanced on each rising
// clock edge and compared with the design on each falling edge. Directed
// checks measure the clock and capture the serial stream independently.
module mdio_master_test;
    localparam int SPEED_W = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [SPEED_W-1:0] speed;
    logic               no_preamble;
    logic               start;
    logic               op_read;
    logic [4:0]         phy_addr;
    logic [4:0]         reg_addr;
    logic [15:0]        wr_data;
    logic               mdio_in;
    logic               mdc;
    logic               mdio_out;
    logic               mdio_oe;
    logic [15:0]        rd_data;
    logic               done;

    always #2 clk = ~clk;   // 250 MHz

    mdio_master #(.SPEED_W(SPEED_W)) uut (
        .clk(clk), .rst_n(rst_n), .speed(speed), .no_preamble(no_preamble),
        .start(start), .op_read(op_read), .phy_addr(phy_addr),
        .reg_addr(reg_addr), .wr_data(wr_data), .mdio_in(mdio_in),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .rd_data(rd_data), .done(done)
    );

    int vectors = 0;
    int fails   = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_n, m_cnt, m_sent, m_total;
    bit          m_mdc, m_rise, m_fall, m_busy, m_out, m_oe, m_done, m_isread;
    bit          nr, nf;
    logic [15:0] m_rd, m_cap;
    bit [1:0]    m_q[$];
    bit [1:0]    m_b;
    logic [31:0] m_body;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_cnt = 0; m_mdc = 0; m_rise = 0; m_fall = 0;
            m_busy = 0; m_out = 0; m_oe = 0; m_done = 0; m_isread = 0;
            m_rd = 0; m_cap = 0; m_sent = 0; m_total = 0; m_q.delete();
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start && speed != 0) begin
                    m_q.delete();
                    if (!no_preamble)
                        for (int i = 0; i < 32; i++) m_q.push_back(2'b11);
                    m_body = {2'b01, op_read ? 2'b10 : 2'b01, phy_addr, reg_addr,
                              op_read ? 2'b00 : 2'b10, op_read ? 16'h0 : wr_data};
                    for (int i = 31; i >= 0; i--)
                        m_q.push_back({m_body[i], !(op_read && i < 18)});
                    m_total = m_q.size(); m_sent = 0;
                    m_busy = 1; m_isread = op_read; m_cap = 0; m_rd = 0;
                end
            end else begin
                if (m_fall) begin
                    if (m_q.size() > 0) begin
                        m_b = m_q.pop_front();
                        m_out = m_b[1]; m_oe = m_b[0]; m_sent++;
                    end else begin
                        m_busy = 0; m_done = 1; m_out = 0; m_oe = 0;
                        if (m_isread) m_rd = m_cap;
                    end
                end
                if (m_rise && m_isread && m_sent > m_total - 16)
                    m_cap = {m_cap[14:0], mdio_in};
            end
            nr = 0; nf = 0;
            if (m_n == 0) begin
                m_mdc = 0;
                if (speed != 0) begin m_n = speed; m_cnt = 0; end
            end else if (m_cnt == 2 * m_n - 1) begin
                m_cnt = 0;
                nf = m_mdc;
                nr = !m_mdc && speed != 0;
                m_mdc = (speed == 0) ? 1'b0 : !m_mdc;
                m_n = speed;
            end else begin
                m_cnt++;
            end
            m_rise = nr; m_fall = nf;
        end
    end

    // ---------------- monitor, PHY stand-in, measurements ----------------
    logic [15:0] phy_word = 16'h0;
    int  cyc = 0, last_rise = -1, last_fall = -1, per = 0, hi_len = 0, lo_len = 0;
    int  rises = 0, done_cnt = 0, ncap = 0, d;
    bit  pmdc = 0;
    logic [63:0] cap = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(mdc == m_mdc,           "R1,R2,R5 mdc vs model", mdc, m_mdc);
            check(mdio_oe == m_oe,        "R8 mdio_oe vs model", mdio_oe, m_oe);
            check(mdio_out == m_out,      "R7 mdio_out vs model", mdio_out, m_out);
            check(done == m_done,         "R10 done vs model", done, m_done);
            check(rd_data === m_rd,       "R9 rd_data vs model", rd_data, m_rd);
        end
        if (mdc && !pmdc) begin
            if (last_rise >= 0) per = cyc - last_rise;
            if (last_fall >= 0) lo_len = cyc - last_fall;
            last_rise = cyc; rises++;
            if (mdio_oe) begin cap = {cap[62:0], mdio_out}; ncap++; end
        end
        if (!mdc && pmdc) begin
            hi_len = cyc - last_rise; last_fall = cyc;
        end
        if (done) done_cnt++;
        pmdc = mdc;
        if (m_busy && m_isread && m_sent > m_total - 16) begin
            d = m_sent - 1 - (m_total - 16);
            mdio_in = phy_word[15 - d];
        end else begin
            mdio_in = 1'b0;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] w);
        @(negedge clk);
        op_read = rd; phy_addr = p; reg_addr = r; wr_data = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        int k = 0;
        while (!done && k < lim) begin @(negedge clk); k++; end
        tick(3);
    endtask

    task automatic clear_obs();
        done_cnt = 0; ncap = 0; cap = '0;
    endtask

    task automatic wait_rise();
        int r0 = rises;
        while (rises == r0) @(negedge clk);
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int r_hold;
        rst_n = 1'b0; speed = '0; no_preamble = 1'b0; start = 1'b0;
        op_read = 1'b0; phy_addr = '0; reg_addr = '0; wr_data = '0; mdio_in = 1'b0;
        tick(4);
        // R11: reset state
        check({mdc, mdio_out, mdio_oe, done} == 4'b0, "R11 reset outputs", {mdc, mdio_out, mdio_oe, done}, 0);
        check(rd_data == 16'h0, "R11 reset rd_data", rd_data, 0);
        rst_n = 1'b1;

        // R2 / R3: stopped clock, start ignored
        tick(10); clear_obs();
        issue(1'b1, 5'h01, 5'h02, 16'h0);
        tick(200);
        check(rises == 0, "R2 no MDC edge while stopped", rises, 0);
        check(done_cnt == 0, "R3 start ignored at zero setting", done_cnt, 0);
        check(ncap == 0, "R3 nothing driven at zero setting", ncap, 0);

        // R1 / R4: N = 5 gives a 20-clock period, 10/10 phases
        speed = 8'd5;
        repeat (3) wait_rise();
        check(per == 20, "R1 period at N=5", per, 20);
        check(hi_len == 10, "R4 high phase at N=5", hi_len, 10);
        check(lo_len == 10, "R4 low phase at N=5", lo_len, 10);

        // R6 / R7 / R8 / R10: write with preamble
        clear_obs();
        issue(1'b0, 5'h13, 5'h0A, 16'hA55A);
        wait_done(4000);
        check(done_cnt == 1, "R10 one done per write", done_cnt, 1);
        check(ncap == 64, "R6 preamble write length", ncap, 64);
        check(cap == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA55A},
              "R7,R8 write stream", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA55A});
        check(mdio_oe == 1'b0, "R10 line released after done", mdio_oe, 0);

        // R8 / R9 / R3: read with preamble, extra start while busy
        clear_obs(); phy_word = 16'hC3A5;
        issue(1'b1, 5'h1F, 5'h11, 16'hFFFF);
        tick(100);
        issue(1'b0, 5'h00, 5'h00, 16'h1234);
        wait_done(4000);
        check(rd_data == 16'hC3A5, "R9 read result", rd_data, 16'hC3A5);
        check(done_cnt == 1, "R3 start while busy ignored", done_cnt, 1);
        check(ncap == 46, "R8 read drives only up to address", ncap, 46);
        check(cap[45:0] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h1F, 5'h11},
              "R7 read header", cap[45:0], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h1F, 5'h11});

        // R6 / R9: read without preamble at N = 1
        speed = 8'd1; no_preamble = 1'b1; tick(10);
        clear_obs(); phy_word = 16'h5A0F;
        issue(1'b1, 5'h04, 5'h1C, 16'h0);
        wait_done(1000);
        check(rd_data == 16'h5A0F, "R9 read result N=1", rd_data, 16'h5A0F);
        check(ncap == 14, "R6 no-preamble read header length", ncap, 14);
        tick(50);
        check(rd_data == 16'h5A0F, "R9 read result held", rd_data, 16'h5A0F);

        // R6 / R7: write without preamble at N = 2
        speed = 8'd2; tick(10); clear_obs();
        issue(1'b0, 5'h0B, 5'h15, 16'h3C96);
        wait_done(2000);
        check(ncap == 32, "R6 no-preamble write length", ncap, 32);
        check(cap[31:0] == {2'b01, 2'b01, 5'h0B, 5'h15, 2'b10, 16'h3C96},
              "R7 no-preamble write stream", cap[31:0], {2'b01, 2'b01, 5'h0B, 5'h15, 2'b10, 16'h3C96});
        check(rd_data == 16'h0, "R9 cleared by next start", rd_data, 0);

        // R5: rate change mid-phase
        no_preamble = 1'b0; speed = 8'd3;
        repeat (2) wait_rise();
        tick(2); speed = 8'd7;
        wait_rise();
        check(hi_len == 6, "R5 phase in progress keeps old length", hi_len, 6);
        check(lo_len == 14, "R5 next phase uses new length", lo_len, 14);

        // R2 / R3: stop while high, then a start at zero
        wait_rise(); tick(3); speed = '0;
        tick(30);
        r_hold = rises; clear_obs();
        issue(1'b0, 5'h02, 5'h03, 16'hBEEF);
        tick(150);
        check(rises == r_hold, "R2 clock parked after zero", rises, r_hold);
        check(mdc == 1'b0, "R2 clock parked low", mdc, 0);
        check(done_cnt == 0, "R3 start ignored after stop", done_cnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule